// File: doc/BRIEF.md
# Burst Beat Address and Strobe Sequencer

This block takes one burst command from an address channel (start address, beat count minus one, transfer size and burst kind) and walks through the burst. For every beat it gives the byte address, a flag that marks the final beat, and the byte-lane enable mask for a data bus `DATA_BYTES` bytes wide. Supported burst kinds are fixed-address, incrementing and wrapping. The wrapping window and the lane mask for narrow transfers on a wide bus are computed from the command.

It sits between a command acceptor and the data path of a memory-side agent. A command is taken only when no burst is in progress. Beats are then offered on a valid/ready port and move forward one per handshake. Commands that cannot be carried out are dropped, and a one-cycle error flag is raised for them.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cmd_ready` is 1 and both `beat_valid` and `cmd_err` are 0.
- R2: `cmd_ready` is high exactly when no burst is active. A legal command taken at a clock edge makes `beat_valid` high in the next cycle, with `beat_addr` equal to `cmd_addr`.
- R3: `cmd_size` selects 2^size bytes per beat. A size greater than log2(`DATA_BYTES`) is rejected: `cmd_err` is high for the one cycle after acceptance, and no beat is produced.
- R4: `cmd_burst` encoding is 0 fixed, 1 incrementing, 2 wrapping. Code 3 is rejected in the same way as R3. A wrapping command whose `cmd_len` is not 1, 3, 7 or 15 is also rejected.
- R5: In a fixed burst, every beat carries the start address.
- R6: In an incrementing burst, each beat after the first has the previous address rounded down to 2^size plus 2^size, modulo 2^`ADDR_W`. Bursts of up to 256 beats are accepted.
- R7: In a wrapping burst, the window is (len+1)·2^size bytes and starts at the start address rounded down to that size. Later beats step by 2^size and return to the window base after they pass its top.
- R8: A burst has `cmd_len`+1 beats. `beat_last` is high only on the beat whose index, counting from 0, equals `cmd_len`.
- R9: `beat_strb` bit i is 1 exactly for the lanes from (addr mod `DATA_BYTES`) up to the last lane of the 2^size-aligned group that contains addr. For example, a 1-byte beat at offset 3 of an 8-byte bus gives 8'b0000_1000.
- R10: While `beat_valid` is high and `beat_ready` is low, `beat_addr`, `beat_last` and `beat_strb` hold their values.
- R11: In the cycle after the handshake of the last beat, `beat_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | 8 | Beats in burst minus one |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_burst | input | 2 | Burst kind: 0 fixed, 1 incrementing, 2 wrapping |
| cmd_err | output | 1 | One-cycle pulse: the accepted command was rejected |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_strb | output | DATA_BYTES | Byte-lane enables of the current beat |

## Verification
The bench computes every expected beat from the requirement formulas and compares the result on every cycle. Directed bursts cover the following cases, and each case separates a different piece of the address logic:
- An unaligned incrementing start, which distinguishes rounding-then-stepping from plain stepping.
- Wrapping starts in the middle of a window, which shows whether the window base is computed correctly.
- Byte-sized beats on the wide bus, which exercise every strobe offset.
- A 256-beat burst and a burst that runs over the top of the address space, which exercise the count limit and the modular address arithmetic.

Illegal sizes, the reserved burst code and wrap lengths that are not allowed are sent to confirm that they are rejected. A long run of random commands under random back-pressure then tests that beats hold their values during a stall, that a new command is taken right after a final beat, and that mixed sequences behave correctly.

// File: rtl/burst_pkg.sv
// Shared types for the burst sequencer.
package burst_pkg;
    // Burst kind as carried on the command port.
    typedef enum logic [1:0] {
        BURST_FIXED = 2'd0,
        BURST_INCR  = 2'd1,
        BURST_WRAP  = 2'd2,
        BURST_RSVD  = 2'd3
    } burst_e;
endpackage

// File: rtl/bag_cmd_check.sv
// Command legality check, purely combinational.
// Flags a size wider than the bus, the reserved burst code, and a wrap
// length other than 2/4/8/16 beats. Assumes LANE_W = log2(bus bytes).
module bag_cmd_check
    import burst_pkg::*;
#(
    parameter int LANE_W = 3
) (
    input  logic [2:0] size,
    input  logic [7:0] len,
    input  burst_e     burst,
    output logic       illegal
);
    logic size_bad, wrap_bad, code_bad;

    // Decode each reason for rejection.
    always_comb begin
        size_bad = int'(size) > LANE_W;
        code_bad = (burst == BURST_RSVD);
        wrap_bad = (burst == BURST_WRAP) &&
                   !((len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15));
        illegal  = size_bad || code_bad || wrap_bad;
    end
endmodule

// File: rtl/bag_next_addr.sv
// Next-beat address, purely combinational.
// Fixed: unchanged. Incrementing: round down to size, add size.
// Wrapping: same step, folded into the (len+1)<<size window.
// Assumes that len+1 is a power of two whenever burst is wrapping.
module bag_next_addr
    import burst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [7:0]        len,
    input  burst_e            burst,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] step, aligned, stepped, win_bytes, win_mask;

    // Step, rounded address and wrap window mask.
    always_comb begin
        step      = ADDR_W'(1) << size;
        aligned   = addr & ~(step - ADDR_W'(1));
        stepped   = aligned + step;
        win_bytes = ADDR_W'({1'b0, len} + 9'd1) << size;
        win_mask  = win_bytes - ADDR_W'(1);
    end

    // Select the update rule by burst kind.
    always_comb begin
        unique case (burst)
            BURST_INCR: nxt = stepped;
            BURST_WRAP: nxt = (aligned & ~win_mask) | (stepped & win_mask);
            default:    nxt = addr;
        endcase
    end
endmodule

// File: rtl/bag_strobe.sv
// Byte-lane enable mask for one beat.
// Enables the lanes from the address offset up to the end of the
// size-aligned lane group holding it. Assumes size <= LANE_W.
module bag_strobe #(
    parameter int DATA_BYTES = 8,
    parameter int LANE_W     = $clog2(DATA_BYTES)
) (
    input  logic [LANE_W-1:0]     offset,
    input  logic [2:0]            size,
    output logic [DATA_BYTES-1:0] strb
);
    logic [LANE_W-1:0] group_mask, hi_lane;

    // Highest lane of the aligned group.
    always_comb begin
        group_mask = LANE_W'((32'd1 << size) - 32'd1);
        hi_lane    = offset | group_mask;
    end

    // One comparator pair per lane.
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign strb[i] = (LANE_W'(i) >= offset) && (LANE_W'(i) <= hi_lane);
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Burst beat sequencer (top).
// Takes one command while idle, then presents one beat per cycle on a
// valid/ready port, moving forward on each handshake, until the final
// beat is taken. Rejected commands raise cmd_err for one cycle and
// produce no beats. DATA_BYTES must be a power of two, at least 2.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 8,
    parameter int LEN_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic [2:0]            cmd_size,
    input  logic [1:0]            cmd_burst,
    output logic                  cmd_err,
    output logic                  beat_valid,
    input  logic                  beat_ready,
    output logic [ADDR_W-1:0]     beat_addr,
    output logic                  beat_last,
    output logic [DATA_BYTES-1:0] beat_strb
);
    localparam int LANE_W = $clog2(DATA_BYTES);

    logic              busy_q, err_q;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [LEN_W-1:0]  len_q, cnt_q;
    logic [2:0]        size_q;
    burst_e            burst_q;
    logic              cmd_illegal, cmd_take, beat_take;

    bag_cmd_check #(.LANE_W(LANE_W)) i_check (
        .size    (cmd_size),
        .len     (cmd_len),
        .burst   (burst_e'(cmd_burst)),
        .illegal (cmd_illegal)
    );

    bag_next_addr #(.ADDR_W(ADDR_W)) i_next (
        .addr  (addr_q),
        .size  (size_q),
        .len   (len_q),
        .burst (burst_q),
        .nxt   (addr_nxt)
    );

    bag_strobe #(.DATA_BYTES(DATA_BYTES), .LANE_W(LANE_W)) i_strb (
        .offset (addr_q[LANE_W-1:0]),
        .size   (size_q),
        .strb   (beat_strb)
    );

    // Handshake decode and output drive.
    always_comb begin
        cmd_ready  = !busy_q;
        cmd_take   = cmd_valid && cmd_ready;
        beat_valid = busy_q;
        beat_addr  = addr_q;
        beat_last  = busy_q && (cnt_q == len_q);
        beat_take  = beat_valid && beat_ready;
        cmd_err    = err_q;
    end

    // Burst state: load on command, advance on beat handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            size_q  <= '0;
            burst_q <= BURST_FIXED;
        end else begin
            err_q <= 1'b0;
            if (cmd_take) begin
                if (cmd_illegal) begin
                    err_q <= 1'b1;
                end else begin
                    busy_q  <= 1'b1;
                    addr_q  <= cmd_addr;
                    len_q   <= cmd_len;
                    size_q  <= cmd_size;
                    burst_q <= burst_e'(cmd_burst);
                    cnt_q   <= '0;
                end
            end else if (beat_take) begin
                if (beat_last) begin
                    busy_q <= 1'b0;
                end else begin
                    addr_q <= addr_nxt;
                    cnt_q  <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Legal command shows its first beat in the following cycle.
    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_illegal |=>
            beat_valid && (beat_addr == $past(cmd_addr)) && !cmd_err);

    // Rejected command pulses the error flag and starts nothing.
    assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_illegal |=> cmd_err && !beat_valid);

    // Fixed bursts keep their address across handshakes.
    assert_fixed_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && (burst_q == BURST_FIXED) |=>
            beat_addr == $past(beat_addr));

    // Mask is non-empty and never wider than the transfer size.
    assert_strb_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_strb != '0) &&
            ($countones(beat_strb) <= (32'd1 << size_q)));

    // Stalled beat keeps all its fields.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
            $stable(beat_strb) && $stable(beat_last));

    // Final handshake returns the block to idle.
    assert_idle_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && beat_last |=> cmd_ready && !beat_valid);
endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
// Bench: behavioural beat model in queues, compared every cycle.
module test_burst_addr_gen;
    localparam int AW = 32;
    localparam int DB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_len = '0;
    logic [2:0]    cmd_size = '0;
    logic [1:0]    cmd_burst = '0;
    logic          cmd_err;
    logic          beat_valid;
    logic          beat_ready = 1'b0;
    logic [AW-1:0] beat_addr;
    logic          beat_last;
    logic [DB-1:0] beat_strb;

    int n_chk = 0;
    int n_fail = 0;
    int rdy_pct = 100;
    int cyc = 0;
    bit after_last = 1'b0;

    logic [AW-1:0] q_addr[$];
    logic          q_last[$];
    logic [DB-1:0] q_strb[$];
    string         q_req[$];

    burst_addr_gen #(.ADDR_W(AW), .DATA_BYTES(DB), .LEN_W(8)) i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
        .cmd_burst(cmd_burst), .cmd_err(cmd_err), .beat_valid(beat_valid),
        .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_last(beat_last),
        .beat_strb(beat_strb)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd0);
            finish_run();
        end
    end

    // Expected lane mask from the requirement wording (R9).
    function automatic logic [DB-1:0] ref_strb(input logic [AW-1:0] a, input int bytes);
        logic [DB-1:0] m = '0;
        longint grp_end = (longint'(a) / bytes) * bytes + bytes - 1;
        int lo = int'(longint'(a) % DB);
        int hi = int'(grp_end % DB);
        for (int i = 0; i < DB; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
        return m;
    endfunction

    // Queue all expected beats of a legal command.
    task automatic model_burst(input logic [AW-1:0] a, input int len, input int size,
                               input int kind);
        int bytes = 1 << size;
        int nb = len + 1;
        longint wsz = longint'(nb) * bytes;
        longint sa = (longint'(a) / bytes) * bytes;
        longint base = (longint'(a) / wsz) * wsz;
        for (int i = 0; i < nb; i++) begin
            logic [AW-1:0] e;
            string r;
            if (i == 0) begin e = a; r = "R2"; end
            else if (kind == 0) begin e = a; r = "R5"; end
            else if (kind == 1) begin e = AW'(sa + longint'(i) * bytes); r = "R6"; end
            else begin e = AW'(base + (sa - base + longint'(i) * bytes) % wsz); r = "R7"; end
            q_addr.push_back(e);
            q_last.push_back(i == len);
            q_strb.push_back(ref_strb(e, bytes));
            q_req.push_back(r);
        end
    endtask

    // Per-cycle compare and ready generation, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit nr;
            if (after_last) begin
                chk(cmd_ready && !beat_valid, "R11", {beat_valid, cmd_ready}, 2'b01);
                after_last = 1'b0;
            end
            if (beat_valid) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R2 unexpected beat", beat_addr, 0);
                end else begin
                    // R10: while stalled the front entry is not popped, so held values are checked here
                    chk(beat_addr == q_addr[0], q_req[0], beat_addr, q_addr[0]);
                    chk(beat_last == q_last[0], "R8", beat_last, q_last[0]);
                    chk(beat_strb == q_strb[0], "R9", beat_strb, q_strb[0]);
                end
            end
            nr = ($urandom % 100) < rdy_pct;
            beat_ready = nr;
            if (beat_valid && nr && q_addr.size() != 0) begin
                if (q_last[0]) after_last = 1'b1;
                void'(q_addr.pop_front());
                void'(q_last.pop_front());
                void'(q_strb.pop_front());
                void'(q_req.pop_front());
            end
        end
    end

    // Offer one command and check how it is taken (R2, R3, R4).
    task automatic send(input logic [AW-1:0] a, input int len, input int size,
                        input int kind);
        bit ill = (size > $clog2(DB)) || (kind == 3) ||
                  (kind == 2 && !(len == 1 || len == 3 || len == 7 || len == 15));
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        if (!ill) model_burst(a, len, size, kind);
        cmd_addr = a; cmd_len = 8'(len); cmd_size = 3'(size); cmd_burst = 2'(kind);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_err == ill, (kind == 3 || kind == 2) ? "R4 err flag" : "R3 err flag",
            cmd_err, ill);
        chk(beat_valid == !ill, "R2 first beat timing", beat_valid, !ill);
    endtask

    task automatic drain();
        @(negedge clk);
        while (q_addr.size() != 0 || !cmd_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_ready && !beat_valid && !cmd_err, "R1 in reset",
            {cmd_ready, beat_valid, cmd_err}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !beat_valid && !cmd_err, "R1 after reset",
            {cmd_ready, beat_valid, cmd_err}, 3'b100);

        // Directed legal bursts, ready always high.
        send(32'h0000_0100, 3, 2, 0);   // R5 fixed
        send(32'h0000_1000, 7, 3, 1);   // R6 aligned
        send(32'h0000_1003, 4, 2, 1);   // R6 unaligned start
        send(32'h0000_2003, 9, 0, 1);   // R9 byte lanes, byte 3 first
        send(32'h0000_0038, 3, 2, 2);   // R7 mid-window: 38,3C,30,34
        send(32'h0000_01F8, 15, 3, 2);  // R7 128-byte window
        send(32'h0000_0005, 1, 0, 2);   // R7 two-beat byte wrap
        send(32'h0000_0006, 7, 1, 2);   // R7 halfword wrap
        send(32'hFFFF_FFF8, 3, 3, 1);   // R6 modular wrap of address space
        drain();

        // Rejections.
        send(32'h0000_0040, 3, 4, 1);   // R3 size too wide
        send(32'h0000_0040, 3, 7, 0);   // R3 largest size
        send(32'h0000_0040, 3, 2, 3);   // R4 reserved code
        send(32'h0000_0040, 2, 2, 2);   // R4 wrap length 3 beats
        send(32'h0000_0040, 31, 2, 2);  // R4 wrap length 32 beats
        drain();

        // Stalls and a 256-beat burst.
        rdy_pct = 40;
        send(32'h0000_3004, 255, 3, 1); // R6, R8 longest
        send(32'h0000_0010, 15, 0, 2);  // R10 under back-pressure
        send(32'h0000_0077, 5, 0, 0);
        drain();

        // Random mix, back-to-back where possible.
        for (int k = 0; k < 80; k++) begin
            int kind = $urandom % 4;
            int size = $urandom % 5;
            int len = (kind == 2) ? ((2 << ($urandom % 4)) - 1) : ($urandom % 20);
            rdy_pct = 30 + ($urandom % 71);
            if (kind == 3 && ($urandom % 3) != 0) kind = 1;
            send($urandom, len, size, kind);
        end
        drain();
        finish_run();
    end
endmodule